// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block produces the read side of a clocked burst access to a NOR-style memory. A master pulls the active-low address strobe low for one clock, and the block captures the start address on that rising edge. It then counts a configured number of wait states and returns one word per clock with a ready flag high. The words come from a small internal store whose contents are computed from the address, so every returned value is predictable.

A configuration write sets the initial latency and the burst mode. In continuous mode the address keeps counting up. Depending on where in its 8-word group the burst began and on the latency setting, the first crossing into the next group may insert extra cycles with ready low. In the fixed-length modes the address wraps inside an aligned group of 8, 16 or 32 words, and the burst ends after that many words.

Top module: `burst_read_seq`

## Requirements
- R1: After reset, `rdy` and `dout` are 0, the wait-state setting is 9 and the mode is continuous.
- R2: The start address is taken from `addr` on a rising edge where `adv_n` is low. `rdy` is low in the cycle that follows. A strobe during a running burst abandons it and starts a new latency count.
- R3: With W wait states, `rdy` first goes high after the W-th rising edge following the strobe edge and shows the start word. It stays low before that.
- R4: A configuration write (`cfg_we` high at a rising edge) with `cfg_wait` in 2..9 sets W and sets the mode from `cfg_mode`. A write with any other `cfg_wait` value changes neither W nor the mode. The mode codes are 0 = continuous, 1 = linear 8, 2 = linear 16 and 3 = linear 32. A new setting applies to bursts strobed after the write.
- R5: In continuous mode each rising edge after the first word presents the next address, wrapping modulo 256. No extra cycle is added at a 128-word boundary.
- R6: In continuous mode, with start offset k = address bits [2:0], the first 8-word crossing inserts max(0, k+W-9) cycles. During these cycles `rdy` is low and `dout` holds the group's last word. Later crossings insert no cycles.
- R7: In linear mode with length L, L words are returned, wrapping within the aligned L-word group with no inserted cycles. After that, `rdy` is low and `dout` holds the last word.
- R8: The word stored at address a is {a XOR 8'hA5, a}, with the upper byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_n | input | 1 | Active-low address strobe |
| addr | input | 8 | Burst start word address |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wait | input | 4 | Wait-state setting to write (2..9 accepted) |
| cfg_mode | input | 2 | Burst mode to write |
| rdy | output | 1 | Valid-data flag |
| dout | output | 16 | Data word |

## Verification
A miscounted latency register shows up as `rdy` rising one edge early or late on the very first word of a burst. A wrong stall count appears as a shifted word sequence, visible at the first word after the 8-word crossing. Wrap or length faults in linear mode show as a wrong address byte in `dout` within at most L cycles, or as `rdy` staying high past the last word. A configuration register that accepts an out-of-range value shows up as a changed latency on the next burst.

// File: rtl/burst_read_seq.sv
`timescale 1ns/1ps
module burst_read_seq #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int GRP = 8,
  parameter int MAXLIN = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_wait,
  input  logic [1:0]    cfg_mode,
  output logic          rdy,
  output logic [DW-1:0] dout
);
  localparam int GB = $clog2(GRP);
  localparam int LW = $clog2(MAXLIN) + 1;

  typedef enum logic [1:0] {IDLE, LAT, DATA, STALL} ph_t;

  ph_t           phase;
  logic [3:0]    wait_cfg, cnt, stall_n;
  logic [1:0]    mode_cfg, bmode;
  logic [AW-1:0] ptr, lmask, nxt_lin, nxt_seq;
  logic [LW-1:0] left;
  logic [4:0]    sum;
  logic [3:0]    stall_calc;

  function automatic logic [DW-1:0] rom(input logic [AW-1:0] a);
    return DW'({a ^ AW'(8'hA5), a});
  endfunction

  function automatic logic [LW-1:0] len_of(input logic [1:0] m);
    return (m == 2'd3) ? LW'(32) : (m == 2'd2) ? LW'(16) : LW'(8);
  endfunction

  assign lmask      = AW'(len_of(bmode) - 1'b1);
  assign nxt_seq    = ptr + 1'b1;
  assign nxt_lin    = (ptr & ~lmask) | (nxt_seq & lmask);
  assign sum        = 5'(addr[GB-1:0]) + 5'(wait_cfg);
  assign stall_calc = (sum > 5'd9) ? 4'(sum - 5'd9) : 4'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cfg <= 4'd9;
      mode_cfg <= 2'd0;
      phase    <= IDLE;
      cnt      <= '0;
      stall_n  <= '0;
      bmode    <= '0;
      ptr      <= '0;
      left     <= '0;
      rdy      <= 1'b0;
      dout     <= '0;
    end else begin
      if (cfg_we && cfg_wait >= 4'd2 && cfg_wait <= 4'd9) begin
        wait_cfg <= cfg_wait;
        mode_cfg <= cfg_mode;
      end
      if (!adv_n) begin
        ptr     <= addr;
        bmode   <= mode_cfg;
        cnt     <= wait_cfg;
        stall_n <= stall_calc;
        left    <= len_of(mode_cfg);
        phase   <= LAT;
        rdy     <= 1'b0;
      end else begin
        case (phase)
          LAT:
            if (cnt == 4'd1) begin
              phase <= DATA;
              rdy   <= 1'b1;
              dout  <= rom(ptr);
            end else cnt <= cnt - 1'b1;
          DATA:
            if (bmode != 2'd0) begin
              if (left == LW'(1)) begin
                phase <= IDLE;
                rdy   <= 1'b0;
              end else begin
                left <= left - 1'b1;
                ptr  <= nxt_lin;
                dout <= rom(nxt_lin);
              end
            end else if (&ptr[GB-1:0] && stall_n != 4'd0) begin
              phase   <= STALL;
              cnt     <= stall_n;
              stall_n <= 4'd0;
              rdy     <= 1'b0;
            end else begin
              ptr  <= nxt_seq;
              dout <= rom(nxt_seq);
            end
          STALL:
            if (cnt == 4'd1) begin
              phase <= DATA;
              rdy   <= 1'b1;
              ptr   <= nxt_seq;
              dout  <= rom(nxt_seq);
            end else cnt <= cnt - 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R2
  strobe_drops_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |=> !rdy);

  // R3
  rdy_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> ($past(phase) == LAT || $past(phase) == STALL));

  // R4
  wait_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cfg >= 4'd2 && wait_cfg <= 4'd9);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == STALL) |-> ($stable(dout) && !rdy));

  // R7
  lin_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && $past(rdy) && bmode != 2'd0) |-> ((ptr & ~lmask) == ($past(ptr) & ~lmask)));
endmodule

// File: tb/burst_read_seq_bench.sv
`timescale 1ns/1ps
module burst_read_seq_bench;
  logic clk = 0, rst_n = 0, adv_n = 1, cfg_we = 0;
  logic [7:0] addr = 0;
  logic [3:0] cfg_wait = 0;
  logic [1:0] cfg_mode = 0;
  logic rdy;
  logic [15:0] dout;
  int checks = 0, failures = 0, cur_w = 9, cur_m = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_read_seq u_burst_read_seq (.clk(clk), .rst_n(rst_n), .adv_n(adv_n), .addr(addr),
    .cfg_we(cfg_we), .cfg_wait(cfg_wait), .cfg_mode(cfg_mode), .rdy(rdy), .dout(dout));

  function automatic logic [15:0] mref(input logic [7:0] a);
    return {a ^ 8'hA5, a};
  endfunction

  // returns {check_data, rdy, data}
  function automatic logic [17:0] expect_at(input logic [7:0] s, input int w, input int m, input int j);
    int i, k, st, n1, L;
    logic [7:0] mask, base;
    if (j < w) return 18'h0;
    i = j - w;
    if (m == 0) begin
      k = int'(s[2:0]);
      st = k + w - 9;
      if (st < 0) st = 0;
      n1 = 8 - k;
      if (i < n1) return {2'b11, mref(8'(int'(s) + i))};
      if (i < n1 + st) return {2'b10, mref(8'(int'(s) + n1 - 1))};
      return {2'b11, mref(8'(int'(s) + i - st))};
    end
    L = 8 << (m - 1);
    mask = 8'(L - 1);
    base = s & ~mask;
    if (i < L) return {2'b11, mref(base | (8'(int'(s) + i) & mask))};
    return {2'b10, mref(base | (8'(int'(s) + L - 1) & mask))};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int w, input int m);
    @(negedge clk);
    cfg_we = 1; cfg_wait = 4'(w); cfg_mode = 2'(m);
    @(negedge clk);
    cfg_we = 0;
    if (w >= 2 && w <= 9) begin cur_w = w; cur_m = m; end
  endtask

  task automatic burst(input logic [7:0] a, input int n, input string req);
    logic [17:0] e;
    @(negedge clk);
    adv_n = 0; addr = a;
    @(negedge clk);
    adv_n = 1;
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      e = expect_at(a, cur_w, cur_m, j);
      check({req, " rdy"}, 16'(rdy), 16'(e[16]));
      if (e[17]) check({req, " data"}, dout, e[15:0]);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int w, m, n;
    logic [7:0] a;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 rdy", 16'(rdy), 16'h0);
    check("R1 dout", dout, 16'h0);
    rst_n = 1;
    burst(8'h03, 24, "R1_R6 default W9 k3");
    burst(8'h00, 20, "R6 W9 k0");
    set_cfg(8, 0);
    burst(8'h11, 20, "R6 W8 k1");
    burst(8'h25, 22, "R6 W8 k5");
    set_cfg(2, 0);
    burst(8'h7C, 16, "R5 128 crossing");
    burst(8'hFA, 12, "R5 wrap 256");
    set_cfg(1, 1);
    burst(8'h40, 8, "R4 reject 1");
    set_cfg(12, 3);
    burst(8'h47, 16, "R4 reject 12");
    set_cfg(5, 2);
    burst(8'h1D, 22, "R7 lin16");
    set_cfg(3, 1);
    burst(8'h36, 14, "R7 lin8");
    set_cfg(4, 3);
    burst(8'hC9, 40, "R7 lin32");
    set_cfg(9, 0);
    burst(8'h07, 5, "R2 abort first");
    burst(8'h56, 20, "R2 after abort");
    for (int r = 0; r < 40; r++) begin
      w = 2 + int'($urandom % 8);
      m = int'($urandom % 4);
      a = 8'($urandom);
      set_cfg(w, m);
      n = (m == 0) ? w + 20 : w + (8 << (m - 1)) + 3;
      if ($urandom % 5 == 0) n = 1 + int'($urandom % 10);
      burst(a, n, "R3_R8 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule